// File: doc/BRIEF.md
# Typed Round-Robin Element Scheduler

This block holds a small registration table describing the processing elements attached to an on-chip network. Each slot records whether it is in use, the network node address of the element, and a kind code (packetizer, register file, ALU, FPU, memory controller, custom). The instruction packetizer asks for an element of one kind per lookup. The block answers with the node address and slot of an element of that kind. It issues one lookup for each element that an instruction must visit.

When several registered elements share a kind, successive lookups for that kind rotate through them in slot order. This spreads the work without any busy or load signal from the elements. Each kind keeps its own rotation state. A registration port lets elements be added, moved or retired while lookups continue. A lookup for a kind with nothing registered returns an error instead of an address.

Top module: `elementScheduler`

## Requirements
- R1: A registration write (`regWrEn`) stores `regValid`, `regAddr` and `regKind` into slot `regSlot`. A lookup in the same cycle still sees the old slot contents, and the write applies from the next cycle on. Kind codes are 0 packetizer, 1 register file, 2 ALU, 3 FPU, 4 memory controller, 5 custom. Codes 6 and 7 are stored and matched exactly like the others.
- R2: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high. In every other cycle, `rspValid`, `rspError`, `rspAddr` and `rspSlot` are all zero.
- R3: If exactly one valid slot holds the requested kind, every lookup for that kind returns that slot's address and slot index.
- R4: If several valid slots hold the requested kind, the pick is the first matching slot found after the slot last served for that kind. The search goes in ascending index and wraps from the top slot to slot 0.
- R5: Each kind has its own rotation position. It moves only when a lookup for that kind is served. Lookups for other kinds, and lookups that end in an error, leave it unchanged.
- R6: A lookup for a kind with no valid slot gives `rspError` = 1 with `rspAddr` = 0 and `rspSlot` = 0.
- R7: A slot cleared by a registration write (valid = 0) is never returned. This holds even when it is the slot last served for its kind. The rotation then continues from the next matching slot.
- R8: Reset (`rstN` low) empties the table, zeroes the outputs, and sets every kind's rotation so that its first served lookup picks the lowest matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Registration write strobe |
| regSlot | input | IDX_W | Slot being written |
| regValid | input | 1 | New in-use flag for the slot |
| regAddr | input | NODE_W | New node address for the slot |
| regKind | input | 3 | New kind code for the slot |
| reqValid | input | 1 | Lookup request strobe |
| reqKind | input | 3 | Kind code being requested |
| rspValid | output | 1 | Lookup answer present (one cycle after request) |
| rspError | output | 1 | No element of the requested kind was registered |
| rspAddr | output | NODE_W | Node address of the chosen element |
| rspSlot | output | IDX_W | Table slot of the chosen element |

## Verification
The bench builds the block with its defaults: 16 slots and 4-bit node addresses, which is a full 4 × 4 mesh. At that size every slot index can be filled, so the wrap of the rotation from slot 15 back to slot 0 is reached with all six kinds present at once. The bench also exercises a lone element, a kind with no entries, and retiring the slot that a kind's rotation currently rests on. A long pseudo-random mix of writes and lookups then lands writes and lookups in the same cycle and removes entries in the middle of a rotation.

// File: rtl/elemSchedPkg.sv
package elemSchedPkg;

  localparam int KIND_W = 3;
  localparam int KINDS  = 1 << KIND_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_PKTZ = 3'd0,
    KIND_REGF = 3'd1,
    KIND_ALU  = 3'd2,
    KIND_FPU  = 3'd3,
    KIND_MEM  = 3'd4,
    KIND_CUST = 3'd5
  } elemKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tblWr;   // registration write this cycle
    logic lookup;  // a lookup is being searched
    logic ptrAdv;  // lookup served: move rotation, load answer
    logic miss;    // lookup found nothing
  } schedStb_t;

endpackage

// File: rtl/elemSchedCtrl.sv
module elemSchedCtrl
  import elemSchedPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      reqValid,
  input  logic      hit,
  output schedStb_t stb,
  output logic      rspValid,
  output logic      rspError
);

  always_comb begin
    stb.tblWr  = regWrEn;
    stb.lookup = reqValid;
    stb.ptrAdv = reqValid & hit;
    stb.miss   = reqValid & ~hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= stb.lookup;
      rspError <= stb.miss;
    end
  end

endmodule

// File: rtl/elemSchedData.sv
module elemSchedData
  import elemSchedPkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int NODE_W = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  schedStb_t         stb,
  input  logic [IDX_W-1:0]  regSlot,
  input  logic              regValid,
  input  logic [NODE_W-1:0] regAddr,
  input  logic [KIND_W-1:0] regKind,
  input  logic [KIND_W-1:0] reqKind,
  output logic              hit,
  output logic [NODE_W-1:0] rspAddr,
  output logic [IDX_W-1:0]  rspSlot
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  logic              tblValid [SLOTS];
  logic [NODE_W-1:0] tblAddr  [SLOTS];
  logic [KIND_W-1:0] tblKind  [SLOTS];
  logic [IDX_W-1:0]  ptrQ     [KINDS];

  logic [SLOTS-1:0]  matchVec;
  logic [IDX_W-1:0]  ptrCur;
  logic [IDX_W-1:0]  pickSlot;

  // registration table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) begin
        tblValid[s] <= 1'b0;
        tblAddr[s]  <= '0;
        tblKind[s]  <= '0;
      end
    end else if (stb.tblWr && (int'(regSlot) < SLOTS)) begin
      tblValid[regSlot] <= regValid;
      tblAddr[regSlot]  <= regAddr;
      tblKind[regSlot]  <= regKind;
    end
  end

  // which slots could serve this lookup
  for (genvar s = 0; s < SLOTS; s++) begin : gMatch
    assign matchVec[s] = tblValid[s] && (tblKind[s] == reqKind);
  end

  assign ptrCur = ptrQ[reqKind];

  // circular search starting just after the last served slot
  always_comb begin
    logic [IDX_W:0] probe;
    hit      = 1'b0;
    pickSlot = '0;
    for (int k = 1; k <= SLOTS; k++) begin
      probe = (IDX_W+1)'(ptrCur) + (IDX_W+1)'(k);
      if (probe >= (IDX_W+1)'(SLOTS)) probe = probe - (IDX_W+1)'(SLOTS);
      if (!hit && matchVec[probe[IDX_W-1:0]]) begin
        hit      = 1'b1;
        pickSlot = probe[IDX_W-1:0];
      end
    end
  end

  // per-kind rotation positions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < KINDS; t++) ptrQ[t] <= LAST_SLOT;
    end else if (stb.ptrAdv) begin
      ptrQ[reqKind] <= pickSlot;
    end
  end

  // answer register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAddr <= '0;
      rspSlot <= '0;
    end else if (stb.ptrAdv) begin
      rspAddr <= tblAddr[pickSlot];
      rspSlot <= pickSlot;
    end else begin
      rspAddr <= '0;
      rspSlot <= '0;
    end
  end

  // R3
  lone_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lookup && $countones(matchVec) == 1) |-> (hit && matchVec[pickSlot]));

  // R4
  rotate_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lookup && $countones(matchVec) >= 2) |-> (pickSlot != ptrCur));

  for (genvar t = 0; t < KINDS; t++) begin : gPtrChk
    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.ptrAdv && reqKind == KIND_W'(t)) |=> $stable(ptrQ[t]));
  end

endmodule

// File: rtl/elementScheduler.sv
module elementScheduler
  import elemSchedPkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int NODE_W = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regSlot,
  input  logic              regValid,
  input  logic [NODE_W-1:0] regAddr,
  input  logic [2:0]        regKind,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  output logic              rspValid,
  output logic              rspError,
  output logic [NODE_W-1:0] rspAddr,
  output logic [IDX_W-1:0]  rspSlot
);

  schedStb_t stb;
  logic      hit;

  elemSchedCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .reqValid (reqValid),
    .hit      (hit),
    .stb      (stb),
    .rspValid (rspValid),
    .rspError (rspError)
  );

  elemSchedData #(.SLOTS(SLOTS), .NODE_W(NODE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSlot  (regSlot),
    .regValid (regValid),
    .regAddr  (regAddr),
    .regKind  (regKind),
    .reqKind  (reqKind),
    .hit      (hit),
    .rspAddr  (rspAddr),
    .rspSlot  (rspSlot)
  );

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (rspValid && rspAddr == '0 && rspSlot == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspError && rspAddr == '0 && rspSlot == '0));

endmodule

// File: tb/elementScheduler_test.sv
module elementScheduler_test;

  localparam int SLOTS  = 16;
  localparam int NODE_W = 4;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              regWrEn;
  logic [IDX_W-1:0]  regSlot;
  logic              regValid;
  logic [NODE_W-1:0] regAddr;
  logic [2:0]        regKind;
  logic              reqValid;
  logic [2:0]        reqKind;
  logic              rspValid;
  logic              rspError;
  logic [NODE_W-1:0] rspAddr;
  logic [IDX_W-1:0]  rspSlot;

  elementScheduler #(.SLOTS(SLOTS), .NODE_W(NODE_W)) uut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSlot(regSlot), .regValid(regValid),
    .regAddr(regAddr), .regKind(regKind),
    .reqValid(reqValid), .reqKind(reqKind),
    .rspValid(rspValid), .rspError(rspError),
    .rspAddr(rspAddr), .rspSlot(rspSlot)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference
  bit mValid [SLOTS];
  int mAddr  [SLOTS];
  int mKind  [SLOTS];
  int mLast  [8];
  int eValid, eErr, eAddr, eSlot;

  task automatic modelEdge();
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) begin mValid[s] = 0; mAddr[s] = 0; mKind[s] = 0; end
      for (int t = 0; t < 8; t++) mLast[t] = SLOTS - 1;
      eValid = 0; eErr = 0; eAddr = 0; eSlot = 0;
    end else begin
      eValid = reqValid; eErr = 0; eAddr = 0; eSlot = 0;
      if (reqValid) begin
        bit found;
        found = 0;
        for (int k = 1; k <= SLOTS; k++) begin
          int s;
          s = (mLast[reqKind] + k) % SLOTS;
          if (!found && mValid[s] && mKind[s] == int'(reqKind)) begin
            found = 1; eAddr = mAddr[s]; eSlot = s;
          end
        end
        if (found) mLast[reqKind] = eSlot;
        else eErr = 1;
      end
      if (regWrEn) begin
        mValid[regSlot] = regValid;
        mAddr[regSlot]  = regAddr;
        mKind[regSlot]  = regKind;
      end
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checks++;
    if (int'(rspValid) != eValid || int'(rspError) != eErr ||
        int'(rspAddr) != eAddr || int'(rspSlot) != eSlot) begin
      fails++;
      $display("FAIL %s: got valid=%0d err=%0d addr=%0d slot=%0d, expected valid=%0d err=%0d addr=%0d slot=%0d",
               tag, rspValid, rspError, rspAddr, rspSlot, eValid, eErr, eAddr, eSlot);
    end
  endtask

  task automatic quiet();
    regWrEn = 0; reqValid = 0; regSlot = 0; regValid = 0;
    regAddr = 0; regKind = 0; reqKind = 0;
  endtask

  task automatic put(input int slot, input bit v, input int addr, input int kind, input string tag);
    quiet();
    regWrEn = 1; regSlot = IDX_W'(slot); regValid = v;
    regAddr = NODE_W'(addr); regKind = 3'(kind);
    cycle(tag);
  endtask

  task automatic ask(input int kind, input string tag);
    quiet();
    reqValid = 1; reqKind = 3'(kind);
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned lfsr;
    quiet();
    rstN = 0;
    // R8: outputs stay zero in reset
    repeat (3) cycle("R8");
    rstN = 1;
    // R6: empty table
    ask(2, "R6");
    ask(3, "R6");
    // R1: write and lookup in the same cycle sees the old table
    quiet();
    regWrEn = 1; regSlot = 5; regValid = 1; regAddr = 9; regKind = 2;
    reqValid = 1; reqKind = 2;
    cycle("R1");
    // R3: lone ALU
    repeat (3) ask(2, "R3");
    // R4: three FPUs rotate in slot order
    put(12, 1, 3, 3, "R1");
    put(2, 1, 11, 3, "R1");
    put(7, 1, 14, 3, "R1");
    ask(3, "R4"); ask(3, "R4"); ask(3, "R4"); ask(3, "R4");
    // R5: other kinds and misses do not move FPU rotation
    ask(2, "R5"); ask(4, "R5"); ask(4, "R6");
    ask(3, "R5");
    // R7: retire slot 12, then the slot the rotation rests on
    put(12, 0, 0, 3, "R7");
    ask(3, "R7"); ask(3, "R7");
    put(7, 0, 0, 3, "R7");
    ask(3, "R7"); ask(3, "R3");
    // R1: codes 6 and 7 match exactly
    put(0, 1, 6, 7, "R1");
    ask(7, "R1"); ask(6, "R6");
    // R4: fill every slot, all kinds, several full rotations with wrap
    for (int s = 0; s < SLOTS; s++) put(s, 1, 15 - s, s % 6, "R1");
    for (int r = 0; r < 4; r++)
      for (int t = 0; t < 6; t++) ask(t, "R4");
    // idle cycles
    quiet(); cycle("R2"); cycle("R2");
    // mixed pseudo-random traffic
    lfsr = 32'h1ACE5EED;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      quiet();
      regWrEn  = lfsr[3] & lfsr[4];
      regSlot  = lfsr[8:5];
      regValid = lfsr[9] | lfsr[10];
      regAddr  = lfsr[14:11];
      regKind  = 3'(lfsr[17:15] % 6);
      reqValid = lfsr[18] | lfsr[19];
      reqKind  = 3'(lfsr[22:20] % 7);
      cycle("R5");
    end
    // R8: mid-run reset empties the table
    quiet(); rstN = 0;
    cycle("R8"); cycle("R8");
    rstN = 1;
    ask(2, "R8"); ask(3, "R8");
    put(9, 1, 4, 1, "R1"); put(3, 1, 8, 1, "R1");
    ask(1, "R8"); ask(1, "R4");
    quiet(); cycle("R2");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule